// File: doc/BRIEF.md
# Dual Data Value Match Selector

This block watches the data phase of bus transfers and tests each qualified transfer against two independent data comparators, called G and H. Each comparator holds its own reference value, an access size (byte, 16-bit half word or 32-bit long word) and a relation. The relation can be equality, inequality, or one of the signed or unsigned ordering tests. A small register-style configuration port loads the references, the per-comparator controls and a selector mode. The selector mode picks which combined result goes to a downstream watchpoint: nothing, G alone, H alone, G AND H, or G OR H.

A range window is built by pairing the two comparators. For example, G set to greater-than 0x50 and H set to less-than 0x70, combined with AND, flags values strictly between the two bounds. The block also reports the two raw comparator results next to the combined output. Address matching, event counting and any halt action belong to the consumer of these outputs.

Top module: `dvm_match_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `g_hit`, `h_hit` and `sel_hit` are 0, both comparators hold relation off, size byte and reference 0, and the selector mode is off.
- R2: A write with `cfg_we` high loads the register at `cfg_addr`. The map is: 0 = G reference, 1 = G control, 2 = H reference, 3 = H control, 4 = selector mode. A control word carries the size in bits [1:0] and the relation in bits [7:4]. The selector mode sits in bits [2:0]. A write acts on the transfers of later cycles; a transfer in the same cycle as the write uses the old setting.
- R3: The size code is 0 = byte, 1 = half word, 2 = long word, 3 = none. A comparator never matches when the transfer's `bus_size` differs from its configured size, and never matches when its configured size is 3.
- R4: The byte operand is taken from data bits [8*lane+7 : 8*lane], where lane is `bus_lane`. The half-word operand is taken from bits [15:0] when `bus_lane[1]` is 0 and from bits [31:16] when it is 1. A long word uses all 32 bits and ignores the lane. The reference always uses its low bits at the configured size.
- R5: Relation code 1 (equal) matches when the sized operand equals the sized reference. Code 2 (not equal) matches when they differ.
- R6: Relation codes 3 (less than), 4 (greater than), 5 (less or equal) and 6 (greater or equal) compare both sized values as two's complement numbers at the configured size.
- R7: Relation codes 7 (less than), 8 (greater than), 9 (less or equal) and 10 (greater or equal) compare both sized values as unsigned numbers.
- R8: Relation code 0 (off) and any code above 10 never produce a match.
- R9: `sel_hit` follows the selector mode: 0 = always 0, 1 = G result, 2 = H result, 3 = G AND H, 4 = G OR H, and codes 5 to 7 = always 0.
- R10: The three outputs are registered. They show the result of the transfer presented at the previous clock edge, and they are 0 after any edge at which `bus_valid` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (3) | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | A data transfer is present this cycle |
| bus_data | input | 32 | Transfer data |
| bus_size | input | 2 | Transfer size code |
| bus_lane | input | 2 | Byte lane of the transfer's low byte |
| g_hit | output | 1 | Comparator G matched the previous transfer |
| h_hit | output | 1 | Comparator H matched the previous transfer |
| sel_hit | output | 1 | Combined selector result for the previous transfer |

## Verification
The assertions assume that `bus_valid` and `bus_size` hold known values at every clock edge once reset is released. They also assume that the configuration written at an edge decides the following edge's results. The bench keeps within this by changing every input only on the falling clock edge, always driving defined values, and holding reset for two full cycles before the first transfer. Undefined relation and selector codes and size code 3 are sent only through the configuration port. Random transfers are mixed with configuration writes to the same comparator, so the old-setting rule for a write in the same cycle is exercised without breaking these assumptions.

// File: rtl/dvm_pkg.sv
package dvm_pkg;

    localparam int DATA_W      = 32;
    localparam int SIZE_W      = 2;
    localparam int REL_W       = 4;
    localparam int SEL_W       = 3;
    localparam int CTL_REL_LSB = 4;
    localparam int NUM_CMP     = 2;
    localparam int CMP_G       = 0;
    localparam int CMP_H       = 1;
    localparam int ADR_SEL     = 2 * NUM_CMP;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    typedef enum logic [REL_W-1:0] {
        REL_OFF = 4'd0,
        REL_EQ  = 4'd1,
        REL_NE  = 4'd2,
        REL_LT  = 4'd3,
        REL_GT  = 4'd4,
        REL_LE  = 4'd5,
        REL_GE  = 4'd6,
        REL_ULT = 4'd7,
        REL_UGT = 4'd8,
        REL_ULE = 4'd9,
        REL_UGE = 4'd10
    } rel_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF = 3'd0,
        SEL_G   = 3'd1,
        SEL_H   = 3'd2,
        SEL_AND = 3'd3,
        SEL_OR  = 3'd4
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] refv;
        size_e             sz;
        rel_e              rel;
    } cmp_cfg_t;

    localparam cmp_cfg_t CFG_RESET = '{refv: '0, sz: SZ_BYTE, rel: REL_OFF};

    // True for the relations that read operands as two's complement
    function automatic logic rel_signed(rel_e r);
        return (r == REL_LT) || (r == REL_GT) || (r == REL_LE) || (r == REL_GE);
    endfunction

    // Move the addressed lane down to bit 0
    function automatic logic [DATA_W-1:0] align_lane(logic [DATA_W-1:0] d, size_e sz,
                                                     logic [1:0] lane);
        case (sz)
            SZ_BYTE: return d >> {lane, 3'b000};
            SZ_HALF: return d >> {lane[1], 4'b0000};
            default: return d;
        endcase
    endfunction

    // Keep the bits of the given size and extend by one bit above the long word
    function automatic logic signed [DATA_W:0] widen(logic [DATA_W-1:0] v, size_e sz, logic sgn);
        logic signed [DATA_W:0] w;
        case (sz)
            SZ_BYTE: w = {{(DATA_W - 7){sgn & v[7]}}, v[7:0]};
            SZ_HALF: w = {{(DATA_W - 15){sgn & v[15]}}, v[15:0]};
            default: w = {sgn & v[DATA_W-1], v};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/dvm_cfg_regs.sv
module dvm_cfg_regs
    import dvm_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DATA_W-1:0]          wdata,
    output cmp_cfg_t [NUM_CMP-1:0]     cfg_q,
    output sel_e                       sel_q
);

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
        localparam int REF_ADR = 2 * i;
        localparam int CTL_ADR = 2 * i + 1;
        cmp_cfg_t slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= CFG_RESET;
            end else if (we && (addr == AW'(REF_ADR))) begin
                slot_q.refv <= wdata;
            end else if (we && (addr == AW'(CTL_ADR))) begin
                slot_q.sz  <= size_e'(wdata[SIZE_W-1:0]);
                slot_q.rel <= rel_e'(wdata[CTL_REL_LSB +: REL_W]);
            end
        end

        assign cfg_q[i] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_OFF;
        end else if (we && (addr == AW'(ADR_SEL))) begin
            sel_q <= sel_e'(wdata[SEL_W-1:0]);
        end
    end

endmodule

// File: rtl/dvm_cmp.sv
module dvm_cmp
    import dvm_pkg::*;
(
    input  cmp_cfg_t          cfg,
    input  logic [DATA_W-1:0] bus_data,
    input  size_e             bus_size,
    input  logic [1:0]        bus_lane,
    output logic              hit
);

    logic                   sgn;
    logic signed [DATA_W:0] opd;
    logic signed [DATA_W:0] opr;
    logic                   is_eq;
    logic                   is_lt;
    logic                   rel_ok;

    always_comb begin
        sgn   = rel_signed(cfg.rel);
        opd   = widen(align_lane(bus_data, cfg.sz, bus_lane), cfg.sz, sgn);
        opr   = widen(cfg.refv, cfg.sz, sgn);
        is_eq = (opd == opr);
        is_lt = (opd < opr);
        case (cfg.rel)
            REL_EQ:           rel_ok = is_eq;
            REL_NE:           rel_ok = !is_eq;
            REL_LT, REL_ULT:  rel_ok = is_lt;
            REL_GT, REL_UGT:  rel_ok = !is_lt && !is_eq;
            REL_LE, REL_ULE:  rel_ok = is_lt || is_eq;
            REL_GE, REL_UGE:  rel_ok = !is_lt;
            default:          rel_ok = 1'b0;
        endcase
        hit = rel_ok && (bus_size == cfg.sz) && (cfg.sz != SZ_NONE);
    end

endmodule

// File: rtl/dvm_combine.sv
module dvm_combine
    import dvm_pkg::*;
(
    input  sel_e               mode,
    input  logic [NUM_CMP-1:0] hits,
    output logic               sel_hit
);

    always_comb begin
        case (mode)
            SEL_G:   sel_hit = hits[CMP_G];
            SEL_H:   sel_hit = hits[CMP_H];
            SEL_AND: sel_hit = hits[CMP_G] & hits[CMP_H];
            SEL_OR:  sel_hit = hits[CMP_G] | hits[CMP_H];
            default: sel_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dvm_match_top.sv
module dvm_match_top
    import dvm_pkg::*;
#(
    parameter int CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              bus_valid,
    input  logic [31:0]       bus_data,
    input  logic [1:0]        bus_size,
    input  logic [1:0]        bus_lane,
    output logic              g_hit,
    output logic              h_hit,
    output logic              sel_hit
);

    cmp_cfg_t [NUM_CMP-1:0] cfg_all;
    cmp_cfg_t               cfg_g;
    cmp_cfg_t               cfg_h;
    sel_e                   sel_mode;
    size_e                  bus_sz;
    logic [NUM_CMP-1:0]     hit_d;
    logic                   sel_d;

    assign cfg_g  = cfg_all[CMP_G];
    assign cfg_h  = cfg_all[CMP_H];
    assign bus_sz = size_e'(bus_size);

    dvm_cfg_regs #(.AW(CFG_AW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_all),
        .sel_q (sel_mode)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        dvm_cmp u_cmp (
            .cfg      (cfg_all[i]),
            .bus_data (bus_data),
            .bus_size (bus_sz),
            .bus_lane (bus_lane),
            .hit      (hit_d[i])
        );
    end

    dvm_combine u_comb (
        .mode    (sel_mode),
        .hits    (hit_d),
        .sel_hit (sel_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            g_hit   <= 1'b0;
            h_hit   <= 1'b0;
            sel_hit <= 1'b0;
        end else begin
            g_hit   <= bus_valid & hit_d[CMP_G];
            h_hit   <= bus_valid & hit_d[CMP_H];
            sel_hit <= bus_valid & sel_d;
        end
    end

endmodule

// File: rtl/dvm_match_chk.sv
module dvm_match_chk
    import dvm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_valid,
    input logic [1:0] bus_size,
    input logic [3:0] g_rel,
    input logic [1:0] g_sz,
    input logic [3:0] h_rel,
    input logic [1:0] h_sz,
    input logic [2:0] sel_mode,
    input logic       g_hit,
    input logic       h_hit,
    input logic       sel_hit
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> (!g_hit && !h_hit && !sel_hit)); // R10

    AST_G_SIZE_GATE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (bus_size != g_sz)) |=> !g_hit); // R3

    AST_H_SIZE_GATE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (bus_size != h_sz)) |=> !h_hit); // R3

    AST_G_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (g_rel == REL_OFF) |=> !g_hit); // R8

    AST_H_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (h_rel == REL_OFF) |=> !h_hit); // R8

    AST_SEL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == SEL_OFF) |=> !sel_hit); // R9

    AST_SEL_AND_BOTH: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == SEL_AND) |=> (sel_hit == (g_hit && h_hit))); // R9

    AST_SEL_OR_EITHER: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == SEL_OR) |=> (sel_hit == (g_hit || h_hit))); // R9

    AST_SEL_G_ONLY: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == SEL_G) |=> (sel_hit == g_hit)); // R9

endmodule

bind dvm_match_top dvm_match_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_size  (bus_size),
    .g_rel     (cfg_g.rel),
    .g_sz      (cfg_g.sz),
    .h_rel     (cfg_h.rel),
    .h_sz      (cfg_h.sz),
    .sel_mode  (sel_mode),
    .g_hit     (g_hit),
    .h_hit     (h_hit),
    .sel_hit   (sel_hit)
);

// File: tb/test_dvm_match_top.sv
module test_dvm_match_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_data = '0;
    logic [1:0]  bus_size = '0;
    logic [1:0]  bus_lane = '0;
    logic        g_hit;
    logic        h_hit;
    logic        sel_hit;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [31:0] m_ref [2];
    int          m_sz  [2];
    int          m_rel [2];
    int          m_sel;

    always #10 clk = ~clk;

    dvm_match_top i_dvm_match_top (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bus_valid (bus_valid),
        .bus_data  (bus_data),
        .bus_size  (bus_size),
        .bus_lane  (bus_lane),
        .g_hit     (g_hit),
        .h_hit     (h_hit),
        .sel_hit   (sel_hit)
    );

    function automatic bit m_cmp(logic [31:0] rv, int sz, int rel, logic [31:0] d,
                                 int bsz, int lane);
        longint x, r, span;
        if (bsz != sz || sz == 3) return 1'b0;
        if (rel < 1 || rel > 10) return 1'b0;
        span = (sz == 0) ? 64'd256 : (sz == 1) ? 64'd65536 : 64'h1_0000_0000;
        if (sz == 0)      x = (longint'(d) >> (8 * lane)) % span;
        else if (sz == 1) x = (longint'(d) >> (16 * (lane / 2))) % span;
        else              x = longint'(d);
        r = longint'(rv) % span;
        if (rel >= 3 && rel <= 6) begin
            if (x >= span / 2) x = x - span;
            if (r >= span / 2) r = r - span;
        end
        case (rel)
            1:       return x == r;
            2:       return x != r;
            3, 7:    return x < r;
            4, 8:    return x > r;
            5, 9:    return x <= r;
            default: return x >= r;
        endcase
    endfunction

    function automatic bit m_sel_out(int mode, bit g, bit h);
        case (mode)
            1:       return g;
            2:       return h;
            3:       return g && h;
            4:       return g || h;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ctl(int rel, int sz);
        return (32'(rel) << 4) | 32'(sz);
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 2; i++) begin
            m_ref[i] = '0;
            m_sz[i]  = 0;
            m_rel[i] = 0;
        end
        m_sel = 0;
    endtask

    // One clock: drive after a falling edge, predict, check at the next falling edge
    task automatic cyc(input bit we, input int adr, input logic [31:0] wd, input bit v,
                       input logic [31:0] d, input int sz, input int ln, input string tag);
        bit eg, eh, es;
        cfg_we    = we;
        cfg_addr  = 3'(adr);
        cfg_wdata = wd;
        bus_valid = v;
        bus_data  = d;
        bus_size  = 2'(sz);
        bus_lane  = 2'(ln);
        if (rst) begin
            eg = 0; eh = 0; es = 0;
            m_reset();
        end else begin
            eg = v && m_cmp(m_ref[0], m_sz[0], m_rel[0], d, sz, ln);
            eh = v && m_cmp(m_ref[1], m_sz[1], m_rel[1], d, sz, ln);
            es = v && m_sel_out(m_sel, m_cmp(m_ref[0], m_sz[0], m_rel[0], d, sz, ln),
                                m_cmp(m_ref[1], m_sz[1], m_rel[1], d, sz, ln));
            if (we) begin
                case (adr)
                    0: m_ref[0] = wd;
                    1: begin m_sz[0] = int'(wd[1:0]); m_rel[0] = int'(wd[7:4]); end
                    2: m_ref[1] = wd;
                    3: begin m_sz[1] = int'(wd[1:0]); m_rel[1] = int'(wd[7:4]); end
                    4: m_sel = int'(wd[2:0]);
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        n_chk++;
        if ({g_hit, h_hit, sel_hit} !== {eg, eh, es}) begin
            n_fail++;
            $display("FAIL %s: g/h/sel actual %b%b%b expected %b%b%b (data %h size %0d lane %0d)",
                     tag, g_hit, h_hit, sel_hit, eg, eh, es, d, sz, ln);
        end
    endtask

    task automatic wr(input int adr, input logic [31:0] wd, input string tag);
        cyc(1'b1, adr, wd, 1'b0, 32'h0, 0, 0, tag);
    endtask

    task automatic xf(input logic [31:0] d, input int sz, input int ln, input string tag);
        cyc(1'b0, 0, 32'h0, 1'b1, d, sz, ln, tag);
    endtask

    function automatic logic [31:0] rnd_val();
        case ($urandom_range(0, 3))
            0:       return 32'($urandom_range(0, 3));
            1:       return 32'h80 + 32'($urandom_range(0, 3));
            2:       return 32'hFFFF_FFFE + 32'($urandom_range(0, 3));
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        #(20 * 60000);
        n_fail++;
        $display("FAIL watchdog R10: actual run still going, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        m_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc(0, 0, 0, 1, 32'h0, 0, 0, "R1 reset");
        cyc(0, 0, 0, 1, 32'h0, 0, 0, "R1 reset");
        rst = 1'b0;
        xf(32'h0, 0, 0, "R1 off after reset");

        // R5 equality on long words
        wr(0, 32'h1234_5678, "R2 G ref");
        wr(1, ctl(1, 2), "R2 G ctl");
        wr(4, 32'd1, "R2 sel G");
        xf(32'h1234_5678, 2, 0, "R5 eq hit");
        xf(32'h1234_5679, 2, 3, "R5 eq miss");
        // R2 write in same cycle uses old config
        cyc(1, 1, ctl(2, 2), 1, 32'h1234_5678, 2, 0, "R2 old setting");
        xf(32'h1234_5678, 2, 0, "R5 ne miss");
        xf(32'h0000_0000, 2, 0, "R5 ne hit");
        // R3 size gating
        xf(32'h0000_0000, 0, 0, "R3 size mismatch");
        wr(1, ctl(1, 3), "R3 size none");
        wr(0, 32'h0, "R3 ref0");
        xf(32'h0, 3, 0, "R3 size none never");
        // R4 byte and half lanes
        wr(0, 32'hA5, "R4 G ref");
        wr(1, ctl(1, 0), "R4 G byte eq");
        xf(32'h00A5_0000, 0, 2, "R4 lane2 hit");
        xf(32'h00A5_0000, 0, 1, "R4 lane1 miss");
        xf(32'hA500_0000, 0, 3, "R4 lane3 hit");
        wr(2, 32'h1234_BEEF, "R4 H ref");
        wr(3, ctl(1, 1), "R4 H half eq");
        wr(4, 32'd2, "R9 sel H");
        xf(32'hBEEF_0000, 1, 2, "R4 upper half hit");
        xf(32'hBEEF_0000, 1, 0, "R4 lower half miss");
        xf(32'h0000_BEEF, 1, 1, "R4 lane1 lower half hit");
        // R6 / R7 signed and unsigned bytes
        wr(0, 32'h10, "R6 G ref");
        wr(1, ctl(3, 0), "R6 G byte lt");
        wr(4, 32'd1, "R9 sel G");
        xf(32'h80, 0, 0, "R6 signed lt -128<16");
        wr(1, ctl(7, 0), "R7 G byte ult");
        xf(32'h80, 0, 0, "R7 unsigned 128<16 miss");
        xf(32'h0F, 0, 0, "R7 unsigned 15<16 hit");
        wr(1, ctl(5, 0), "R6 le");
        xf(32'h10, 0, 0, "R6 le equal");
        wr(1, ctl(6, 0), "R6 ge");
        xf(32'hF0, 0, 0, "R6 ge -16>=16 miss");
        wr(1, ctl(10, 0), "R7 uge");
        xf(32'hF0, 0, 0, "R7 uge 240>=16 hit");
        wr(1, ctl(9, 0), "R7 ule");
        xf(32'h11, 0, 0, "R7 ule miss");
        wr(1, ctl(8, 1), "R7 ugt half");
        xf(32'h8000, 1, 0, "R7 ugt half hit");
        wr(1, ctl(4, 1), "R6 gt half");
        xf(32'h8000, 1, 0, "R6 gt half miss");
        // R9 window
        wr(0, 32'h50, "R9 G ref");
        wr(1, ctl(4, 2), "R9 G gt");
        wr(2, 32'h70, "R9 H ref");
        wr(3, ctl(3, 2), "R9 H lt");
        wr(4, 32'd3, "R9 sel AND");
        xf(32'h60, 2, 0, "R9 window inside");
        xf(32'h50, 2, 0, "R9 window low edge");
        xf(32'h70, 2, 0, "R9 window high edge");
        wr(4, 32'd4, "R9 sel OR");
        xf(32'h40, 2, 0, "R9 or low");
        xf(32'h70, 2, 0, "R9 or high");
        // R8 off and undefined codes
        wr(3, ctl(0, 2), "R8 H off");
        xf(32'h40, 2, 0, "R8 or reduces to G");
        wr(4, 32'd3, "R8 and with off");
        xf(32'h60, 2, 0, "R8 and false");
        wr(1, ctl(15, 2), "R8 G undefined");
        xf(32'h60, 2, 0, "R8 undefined never");
        wr(1, ctl(1, 2), "R9 G eq");
        wr(0, 32'h60, "R9 ref");
        wr(4, 32'd6, "R9 sel undefined");
        xf(32'h60, 2, 0, "R9 undefined sel");
        wr(4, 32'd0, "R9 sel off");
        xf(32'h60, 2, 0, "R9 off sel");
        wr(4, 32'd1, "R10 sel G");
        cyc(0, 0, 0, 0, 32'h60, 2, 0, "R10 no valid");
        xf(32'h60, 2, 0, "R10 valid hit");
        wr(5, 32'hFFFF_FFFF, "R2 unmapped addr");
        xf(32'h60, 2, 0, "R2 unmapped no effect");

        // mixed random traffic
        for (int k = 0; k < 2000; k++) begin
            int          adr;
            logic [31:0] wd;
            adr = $urandom_range(0, 5);
            if (adr == 1 || adr == 3) wd = ctl($urandom_range(0, 11), $urandom_range(0, 3));
            else if (adr == 4)        wd = 32'($urandom_range(0, 7));
            else                      wd = rnd_val();
            cyc($urandom_range(0, 3) == 0, adr, wd, $urandom_range(0, 4) != 0,
                rnd_val() << (8 * $urandom_range(0, 3)), $urandom_range(0, 3),
                $urandom_range(0, 3), "R3 R4 R5 R6 R7 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule